// File: doc/BRIEF.md
# Dual-Clock FIFO with Status Flags

This block moves data words between two unrelated clock domains. A producer pushes words on the write clock and a consumer pulls them on the read clock. The write side sees a full flag and a one-cycle write-error strobe. The read side sees an empty flag, a programmable almost-empty flag and a one-cycle read-error strobe. Each side's flags are registered in, or derived from, registers of that side's own clock. The two sides exchange only pointer values, as Gray code passed through synchronizer chains.

A parameter selects one of two read behaviours. In standard mode a word is copied to `rd_data` at the read-clock edge that accepts a read. In prefetch mode (first word falls through) the oldest unread word is already waiting on `rd_data` whenever `empty` is low, and an accepted read moves on to the next word.

The almost-empty flag compares the occupancy seen by the read domain against the `PE_THRESH` parameter. Because that view lags recent writes, the flag errs towards reporting too few words. The depth is `2**ADDR_W` words. Each domain has its own synchronous, active-high reset.

Top module: `dcfifo`

## Requirements
- R1: While its domain's reset is applied, the read side holds `empty` and `prog_empty` high, `rd_err` low and, in standard mode, `rd_data` at zero, and the write side holds `full` and `wr_err` low.
- R2: In standard mode, `rd_data` changes only at a read-clock edge where `rd_en` is high and `empty` is low. It then takes the oldest unread word, and otherwise keeps its value.
- R3: In prefetch mode, whenever `empty` is low, `rd_data` shows the oldest unread word without any read. A read-clock edge with `rd_en` high and `empty` low moves it on to the next word.
- R4: `empty` is high whenever no unread word is held, so a low `empty` always means a word can be taken.
- R5: A read-clock edge with `rd_en` high while `empty` is high consumes nothing and leaves standard-mode `rd_data` unchanged. It makes `rd_err` high for the following read cycle only, and `rd_err` is low in every other cycle.
- R6: `full` is high whenever the words held equal the capacity. The capacity is `2**ADDR_W` in standard mode and one more in prefetch mode, counting the output register. A write-clock edge with `wr_en` high while `full` is high stores nothing and makes `wr_err` high for the next write cycle only, and `wr_err` is low in every other cycle.
- R7: `prog_empty` is high whenever the words held are at most `PE_THRESH`, counting the output register word in prefetch mode. It may stay high longer while writes are still crossing.
- R8: After both sides have been idle for twelve read cycles, the flags are exact. `empty` is high only for zero words, `prog_empty` is high only for at most `PE_THRESH` words, and `full` is high only at capacity.
- R9: Each crossing pointer is a Gray-coded register that changes in at most one bit per edge of its own clock. Every word comes out uncorrupted and in write order while both clocks run at unrelated rates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Write-side synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No room for another word |
| wr_err | output | 1 | Previous write request was refused |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Read-side synchronous reset, active high |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Word read out (standard) or waiting word (prefetch) |
| empty | output | 1 | No word can be taken |
| prog_empty | output | 1 | Occupancy at or below `PE_THRESH` |
| rd_err | output | 1 | Previous read request was refused |

## Verification
The hardest situation to reach from the ports is the flags' behaviour while pointer updates are still in flight. This happens when words are written and read in the same stretch of time on clocks with no common period, so the almost-empty and full views lag by an amount that changes from cycle to cycle. The stimulus runs a long stretch of mixed writes and reads at 200 MHz against 143 MHz, shifting from write-heavy to read-heavy. It checks every cycle that no flag is ever optimistic, and checks the exact flag values only in idle windows inserted between phases. Separate phases drive reads into an empty FIFO and writes into a full one, and both read modes are run side by side from the same stimulus.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/1ps
package dcfifo_pkg;

    // Read-side presentation of data
    typedef enum logic {
        RD_STANDARD = 1'b0,
        RD_PREFETCH = 1'b1
    } rd_mode_e;

    localparam int unsigned PTR_MAX_W = 32;
    typedef logic [PTR_MAX_W-1:0] ptr_word_t;

    // Read-domain flag bundle
    typedef struct packed {
        logic empty;
        logic prog_empty;
        logic err;
    } rd_status_t;

    function automatic ptr_word_t to_gray(input ptr_word_t b);
        return b ^ (b >> 1);
    endfunction

    // Prefix XOR from the top bit down, by doubling shifts
    function automatic ptr_word_t from_gray(input ptr_word_t g);
        ptr_word_t b;
        b = g;
        for (int s = 1; s < int'(PTR_MAX_W); s = s * 2) begin
            b = b ^ (b >> s);
        end
        return b;
    endfunction

endpackage

// File: rtl/dcfifo_sync.sv
`timescale 1ns/1ps
module dcfifo_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dcfifo_ram.sv
`timescale 1ns/1ps
module dcfifo_ram #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) cells[waddr] <= wdata;
    end

    // Unclocked read: the location is stable once its pointer has crossed
    assign rdata = cells[raddr];
endmodule

// File: rtl/dcfifo_wr_ctl.sv
`timescale 1ns/1ps
module dcfifo_wr_ctl
    import dcfifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic [ADDR_W-1:0] waddr,
    output logic              we,
    output logic [ADDR_W:0]   wgray,
    output logic              full,
    output logic              wr_err
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_n;
    logic [PW-1:0] rbin_s;

    assign rbin_s = PW'(from_gray(ptr_word_t'(rgray_sync)));

    // Same slot, opposite wrap bit: the reader is a whole lap behind
    assign full   = (wbin[ADDR_W] != rbin_s[ADDR_W]) &&
                    (wbin[ADDR_W-1:0] == rbin_s[ADDR_W-1:0]);
    assign we     = wr_en && !full;
    assign wbin_n = wbin + PW'(we);
    assign waddr  = wbin[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin   <= '0;
            wgray  <= '0;
            wr_err <= 1'b0;
        end else begin
            wbin   <= wbin_n;
            wgray  <= PW'(to_gray(ptr_word_t'(wbin_n)));
            wr_err <= wr_en && full;
        end
    end

    // A refused write leaves the pointer alone and raises the strobe
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |=> ($stable(wbin) && wr_err));

    // The crossing word moves by a single bit per write edge
    assert_gray_step_wr_R9: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/dcfifo_rd_ctl.sv
`timescale 1ns/1ps
module dcfifo_rd_ctl
    import dcfifo_pkg::*;
#(
    parameter int       DATA_W    = 16,
    parameter int       ADDR_W    = 4,
    parameter rd_mode_e MODE      = RD_STANDARD,
    parameter int       PE_THRESH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wgray_sync,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic [DATA_W-1:0] rd_data,
    output rd_status_t        status
);
    localparam int PW    = ADDR_W + 1;
    localparam int OW    = ADDR_W + 2;
    localparam int DEPTH = 1 << ADDR_W;

    logic [PW-1:0]     rbin;
    logic [PW-1:0]     rbin_n;
    logic [PW-1:0]     wbin_s;
    logic [PW-1:0]     level;
    logic              mem_has;
    logic              advance;
    logic              dout_empty;
    logic [OW-1:0]     occupancy;
    logic [DATA_W-1:0] dout_q;
    logic              err_q;

    assign wbin_s  = PW'(from_gray(ptr_word_t'(wgray_sync)));
    assign level   = wbin_s - rbin;
    assign mem_has = (level != '0);

    generate
        if (MODE == RD_PREFETCH) begin : g_prefetch
            logic held;

            // Refill the output register when it is free or being taken
            assign advance    = mem_has && (!held || rd_en);
            assign dout_empty = !held;
            assign occupancy  = OW'(level) + OW'(held);

            always_ff @(posedge clk) begin
                if (rst) begin
                    held   <= 1'b0;
                    dout_q <= '0;
                end else if (advance) begin
                    held   <= 1'b1;
                    dout_q <= mem_rdata;
                end else if (rd_en) begin
                    held   <= 1'b0;
                end
            end
        end else begin : g_standard
            assign advance    = rd_en && mem_has;
            assign dout_empty = !mem_has;
            assign occupancy  = OW'(level);

            always_ff @(posedge clk) begin
                if (rst) begin
                    dout_q <= '0;
                end else if (advance) begin
                    dout_q <= mem_rdata;
                end
            end

            // A refused read leaves the memory pointer where it was
            assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
                (rd_en && dout_empty) |=> $stable(rbin));
        end
    endgenerate

    assign rbin_n = rbin + PW'(advance);

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
            err_q <= 1'b0;
        end else begin
            rbin  <= rbin_n;
            rgray <= PW'(to_gray(ptr_word_t'(rbin_n)));
            err_q <= rd_en && dout_empty;
        end
    end

    assign raddr             = rbin[ADDR_W-1:0];
    assign rd_data           = dout_q;
    assign status.empty      = dout_empty;
    assign status.prog_empty = (occupancy <= OW'(PE_THRESH));
    assign status.err        = err_q;

    assert_read_error_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && status.empty) |=> status.err);

    assert_empty_implies_low_R7: assert property (@(posedge clk) disable iff (rst)
        status.empty |-> status.prog_empty);

    // The lagging write pointer never appears more than one lap ahead
    assert_level_bound_R6: assert property (@(posedge clk) disable iff (rst)
        level <= PW'(DEPTH));

    assert_gray_step_rd_R9: assert property (@(posedge clk) disable iff (rst)
        $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/dcfifo.sv
`timescale 1ns/1ps
module dcfifo
    import dcfifo_pkg::*;
#(
    parameter int       DATA_W      = 16,
    parameter int       ADDR_W      = 4,
    parameter int       SYNC_STAGES = 2,
    parameter rd_mode_e MODE        = RD_STANDARD,
    parameter int       PE_THRESH   = 3
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    output logic              wr_err,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              prog_empty,
    output logic              rd_err
);
    localparam int PW = ADDR_W + 1;

    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic              we;
    logic [PW-1:0]     wgray;
    logic [PW-1:0]     rgray;
    logic [PW-1:0]     wgray_in_rd;
    logic [PW-1:0]     rgray_in_wr;
    logic [DATA_W-1:0] mem_rdata;
    rd_status_t        st;

    dcfifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wr_clk (wr_clk),
        .we     (we),
        .waddr  (waddr),
        .wdata  (wr_data),
        .raddr  (raddr),
        .rdata  (mem_rdata)
    );

    dcfifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
        .clk        (wr_clk),
        .rst        (wr_rst),
        .wr_en      (wr_en),
        .rgray_sync (rgray_in_wr),
        .waddr      (waddr),
        .we         (we),
        .wgray      (wgray),
        .full       (full),
        .wr_err     (wr_err)
    );

    dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk (rd_clk),
        .rst (rd_rst),
        .d   (wgray),
        .q   (wgray_in_rd)
    );

    dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk (wr_clk),
        .rst (wr_rst),
        .d   (rgray),
        .q   (rgray_in_wr)
    );

    dcfifo_rd_ctl #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .MODE      (MODE),
        .PE_THRESH (PE_THRESH)
    ) u_rd (
        .clk        (rd_clk),
        .rst        (rd_rst),
        .rd_en      (rd_en),
        .wgray_sync (wgray_in_rd),
        .mem_rdata  (mem_rdata),
        .raddr      (raddr),
        .rgray      (rgray),
        .rd_data    (rd_data),
        .status     (st)
    );

    assign empty      = st.empty;
    assign prog_empty = st.prog_empty;
    assign rd_err     = st.err;
endmodule

// File: tb/dcfifo_bench.sv
`timescale 1ns/1ps
// Behavioural reference: one queue of accepted words, checked at every falling edge
module dcfifo_harness
    import dcfifo_pkg::*;
#(
    parameter rd_mode_e MODE   = RD_STANDARD,
    parameter int       ADDR_W = 4,
    parameter int       TH     = 3
) (
    input logic        wr_clk,
    input logic        rd_clk,
    input logic        wr_rst,
    input logic        rd_rst,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic        rd_en,
    input logic        quiet
);
    localparam bit PREF = (MODE == RD_PREFETCH);
    localparam int CAP  = (1 << ADDR_W) + (PREF ? 1 : 0);

    logic        full, wr_err, empty, prog_empty, rd_err;
    logic [15:0] rd_data;

    dcfifo #(.DATA_W(16), .ADDR_W(ADDR_W), .SYNC_STAGES(2), .MODE(MODE),
             .PE_THRESH(TH)) u_dcfifo (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
        .full(full), .wr_err(wr_err),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_data(rd_data),
        .empty(empty), .prog_empty(prog_empty), .rd_err(rd_err)
    );

    int          n_chk = 0;
    int          n_err = 0;
    logic [15:0] q [$];
    logic [15:0] exp_dout = '0;
    logic [15:0] v;
    bit          exp_werr = 1'b0;
    bit          exp_rerr = 1'b0;
    int          wr_rst_seen = 0;
    int          rd_rst_seen = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s [%s mode] %s: actual %0d expected %0d",
                     req, PREF ? "prefetch" : "standard", what, act, exp);
        end
    endtask

    always @(negedge wr_clk) begin
        if (wr_rst) begin
            if (wr_rst_seen >= 2) begin
                chk(full === 1'b0, "R1", "full in reset", full, 0);
                chk(wr_err === 1'b0, "R1", "wr_err in reset", wr_err, 0);
            end
            wr_rst_seen++;
            exp_werr = 1'b0;
        end else begin
            chk(wr_err === exp_werr, "R6", "wr_err strobe", wr_err, exp_werr);
            if (q.size() >= CAP)
                chk(full === 1'b1, "R6", "full at capacity", full, 1);
            if (quiet)
                chk(full === (q.size() >= CAP), "R8", "idle full", full, q.size() >= CAP);
            exp_werr = wr_en && full;
            if (wr_en && !full) q.push_back(wr_data);
        end
    end

    always @(negedge rd_clk) begin
        if (rd_rst) begin
            if (rd_rst_seen >= 2) begin
                chk(empty === 1'b1, "R1", "empty in reset", empty, 1);
                chk(prog_empty === 1'b1, "R1", "prog_empty in reset", prog_empty, 1);
                chk(rd_err === 1'b0, "R1", "rd_err in reset", rd_err, 0);
                if (!PREF) chk(rd_data === 16'h0, "R1", "rd_data in reset", rd_data, 0);
            end
            rd_rst_seen++;
            exp_rerr = 1'b0;
            exp_dout = '0;
        end else begin
            chk(rd_err === exp_rerr, "R5", "rd_err strobe", rd_err, exp_rerr);
            if (!PREF) begin
                chk(rd_data === exp_dout, "R2/R9", "read word", rd_data, exp_dout);
            end else if (!empty) begin
                if (q.size() == 0) chk(1'b0, "R4", "word shown with none held", 1, 0);
                else chk(rd_data === q[0], "R3/R9", "waiting word", rd_data, q[0]);
            end
            if (q.size() == 0)
                chk(empty === 1'b1, "R4", "empty with no word", empty, 1);
            if (q.size() <= TH)
                chk(prog_empty === 1'b1, "R7", "prog_empty at low level", prog_empty, 1);
            if (quiet) begin
                chk(empty === (q.size() == 0), "R8", "idle empty", empty, q.size() == 0);
                chk(prog_empty === (q.size() <= TH), "R8", "idle prog_empty",
                    prog_empty, q.size() <= TH);
            end
            exp_rerr = rd_en && empty;
            if (rd_en && !empty) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R4", "read accepted with no word", 1, 0);
                end else begin
                    v = q.pop_front();
                    if (!PREF) exp_dout = v;
                end
            end
        end
    end
endmodule

module dcfifo_bench;
    import dcfifo_pkg::*;

    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        wr_rst = 1'b1;
    logic        rd_rst = 1'b1;
    logic        wr_en  = 1'b0;
    logic        rd_en  = 1'b0;
    logic [15:0] wr_data = '0;
    logic        quiet  = 1'b0;
    logic [15:0] seq    = 16'h1000;
    bit          done   = 1'b0;
    int          wd_fail = 0;

    always #2.5 wr_clk = ~wr_clk;   // 200 MHz
    always #3.5 rd_clk = ~rd_clk;   // unrelated read clock

    dcfifo_harness #(.MODE(RD_STANDARD), .ADDR_W(4), .TH(3)) u_std (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst(wr_rst), .rd_rst(rd_rst),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .quiet(quiet));

    dcfifo_harness #(.MODE(RD_PREFETCH), .ADDR_W(4), .TH(3)) u_fw (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst(wr_rst), .rd_rst(rd_rst),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .quiet(quiet));

    task automatic wr_run(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge wr_clk); #1;
            wr_en = 1'b1; wr_data = seq; seq = seq + 16'd1;
        end
        @(posedge wr_clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_run(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge rd_clk); #1;
            rd_en = 1'b1;
        end
        @(posedge rd_clk); #1;
        rd_en = 1'b0;
    endtask

    // Idle window in which the flags must be exact (R8)
    task automatic settle();
        repeat (12) @(posedge rd_clk);
        #1 quiet = 1'b1;
        repeat (4) @(posedge rd_clk);
        #1 quiet = 1'b0;
    endtask

    task automatic report();
        int c, e;
        c = u_std.n_chk + u_fw.n_chk + (wd_fail > 0 ? 1 : 0);
        e = u_std.n_err + u_fw.n_err + wd_fail;
        $display("Simulation finished: %0d checks, %0d errors", c, e);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge wr_clk);
        if (!done) begin
            wd_fail = 1;
            $display("FAIL R8 watchdog: actual running expected finished");
            report();
        end
    end

    initial begin
        repeat (6) @(posedge rd_clk);
        @(posedge wr_clk); #1 wr_rst = 1'b0;
        @(posedge rd_clk); #1 rd_rst = 1'b0;
        settle();                 // R1 then R8 at zero words
        rd_run(5);                // R5: reads into an empty FIFO
        settle();
        wr_run(3);                // level equal to threshold (R7)
        settle();
        wr_run(1);                // one above threshold
        settle();
        rd_run(2);                // R2, R3
        settle();
        wr_run(40);               // fill and refused writes (R6)
        settle();
        wr_run(4);                // writes while already full
        settle();
        rd_run(60);               // drain past empty (R5)
        settle();
        fork
            begin
                for (int i = 0; i < 1500; i++) begin
                    @(posedge wr_clk); #1;
                    wr_en = ($urandom_range(0, 99) < (i < 750 ? 65 : 35));
                    wr_data = seq; seq = seq + 16'd1;
                end
                @(posedge wr_clk); #1 wr_en = 1'b0;
            end
            begin
                for (int i = 0; i < 1100; i++) begin
                    @(posedge rd_clk); #1;
                    rd_en = ($urandom_range(0, 99) < (i < 550 ? 35 : 75));
                end
                @(posedge rd_clk); #1 rd_en = 1'b0;
            end
        join
        settle();
        rd_run(80);
        settle();
        done = 1'b1;
        report();
    end
endmodule